// File: doc/BRIEF.md
# MMU Control and Fault Register File

This block is the software-visible register bank of a small memory management unit. It stores the control flags, the translation table base and the domain access control word. It also keeps a record of the most recent data abort, made up of the domain, the access type, the internal/external flag and the faulting virtual address. A coprocessor-style port picks a register by number. Reads are combinational from that number. Writes take effect at the clock edge.

Two register numbers behave differently for reads and writes. A read returns the stored fault information. A write becomes a maintenance command to the TLB. On one number the command flushes every entry. On the other it invalidates the entry that matches a given virtual address. Only data aborts update the fault record. Prefetch aborts leave it alone. The table walker, the TLB array and the permission checker sit outside this block and use its outputs.

Top module: `mmu_cfg_regs`

## Requirements
- R1: After reset, register 1 reads 0x040 and registers 2, 3, 5 and 6 read zero. tlb_flush and tlb_purge are low. The read data follows reg_sel combinationally.
- R2: A write to register 1 stores wr_data[9:0] as the control flags. From bit 0 upward these are: MMU enable, alignment check, cache enable, write buffer enable, P, D, fixed bit, big-endian, S and R. Bit 6 always reads 1, and bits 31:10 read 0.
- R3: A write to register 2 stores the table base. Bits 13:0 read back zero, and table_base carries the same aligned value.
- R4: A write to register 3 stores the domain word. Domain n's 2-bit field sits at bits [2n+1:2n] of dom_perm and of the read data.
- R5: A data abort captures fault status {domain[7:4], type[3:1], external[0]} into register 5 and the virtual address into register 6. Both are visible after the edge.
- R6: A prefetch abort changes neither register 5 nor register 6.
- R7: A write to register 5 drives tlb_flush high for exactly the one cycle after the write edge. The stored status is unchanged.
- R8: A write to register 6 drives tlb_purge high for exactly one cycle, with purge_va equal to the written data. The stored fault address is unchanged.
- R9: Reserved numbers (0, 4, 7 to 15) read zero. Writes to them change no register and raise no strobe.
- R10: When a data abort and a register-5 write fall in the same cycle, the status takes the abort's values and the flush strobe still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for the selected register |
| reg_sel | input | 4 | Register number |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| dabort | input | 1 | Data abort capture request |
| pabort | input | 1 | Prefetch abort (never captured) |
| abort_dom | input | 4 | Domain of the faulting access |
| abort_type | input | 3 | Access type code |
| abort_ext | input | 1 | 1 = external fault |
| abort_va | input | 32 | Faulting virtual address |
| ctrl_flags | output | 10 | Control flags |
| table_base | output | 32 | Aligned translation table base |
| dom_perm | output | 32 | Sixteen 2-bit domain fields |
| tlb_flush | output | 1 | Whole-TLB flush strobe |
| tlb_purge | output | 1 | Single-entry purge strobe |
| purge_va | output | 32 | Address to purge, valid with tlb_purge |

## Verification
The control register is written with all ones, all zeros and a sparse pattern. These show that the fixed bit is forced and the upper bits are dropped. The base is written with all ones, which reveals any alignment bits that leak through. The domain word uses an asymmetric pattern so that a shifted or reversed field order shows up. Fault capture is run with a data abort, then a prefetch abort with different values, then maintenance writes carrying foreign data. This separates capture from hold. A collision cycle and a sweep of the reserved numbers with all-ones data cover priority and decode leakage.

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs #(
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 4,
  parameter int CTRL_W     = 10,
  parameter int FIXED_BIT  = 6,
  parameter int ALIGN_BITS = 14,
  parameter int DOM_N      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dabort,
  input  logic              pabort,
  input  logic [3:0]        abort_dom,
  input  logic [2:0]        abort_type,
  input  logic              abort_ext,
  input  logic [DATA_W-1:0] abort_va,
  output logic [CTRL_W-1:0] ctrl_flags,
  output logic [DATA_W-1:0] table_base,
  output logic [DATA_W-1:0] dom_perm,
  output logic              tlb_flush,
  output logic              tlb_purge,
  output logic [DATA_W-1:0] purge_va
);
  localparam int DOM_W = 2 * DOM_N;
  localparam int FSR_W = 8;
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_DOM  = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_FSR  = SEL_W'(5);
  localparam logic [SEL_W-1:0] SEL_FAR  = SEL_W'(6);
  localparam logic [CTRL_W-1:0] FIX_MASK = CTRL_W'(1) << FIXED_BIT;

  logic [CTRL_W-1:0]          ctrl_q;
  logic [DATA_W-1:ALIGN_BITS] base_q;
  logic [DOM_W-1:0]           dom_q;
  logic [FSR_W-1:0]           fsr_q;
  logic [DATA_W-1:0]          far_q;
  logic                       flush_q, purge_q;
  logic [DATA_W-1:0]          pva_q;

  wire wr_ctrl = wr_en && (reg_sel == SEL_CTRL);
  wire wr_base = wr_en && (reg_sel == SEL_BASE);
  wire wr_dom  = wr_en && (reg_sel == SEL_DOM);
  wire wr_fsr  = wr_en && (reg_sel == SEL_FSR);
  wire wr_far  = wr_en && (reg_sel == SEL_FAR);
  wire [FSR_W-1:0] fsr_new = {abort_dom, abort_type, abort_ext};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= FIX_MASK;
      base_q <= '0;
      dom_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0] | FIX_MASK;
      if (wr_base) base_q <= wr_data[DATA_W-1:ALIGN_BITS];
      if (wr_dom)  dom_q  <= wr_data[DOM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (dabort) begin
      fsr_q <= fsr_new;
      far_q <= abort_va;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      purge_q <= 1'b0;
      pva_q   <= '0;
    end else begin
      flush_q <= wr_fsr;
      purge_q <= wr_far;
      if (wr_far) pva_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
      SEL_BASE: rd_data = {base_q, {ALIGN_BITS{1'b0}}};
      SEL_DOM:  rd_data[DOM_W-1:0] = dom_q;
      SEL_FSR:  rd_data[FSR_W-1:0] = fsr_q;
      SEL_FAR:  rd_data = far_q;
      default:  rd_data = '0;
    endcase
  end

  assign ctrl_flags = ctrl_q;
  assign table_base = {base_q, {ALIGN_BITS{1'b0}}};
  assign dom_perm   = {{(DATA_W-DOM_W){1'b0}}, dom_q};
  assign tlb_flush  = flush_q;
  assign tlb_purge  = purge_q;
  assign purge_va   = pva_q;

  a_r2_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_flags[FIXED_BIT]);
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    dabort |=> (fsr_q == $past(fsr_new)) && (far_q == $past(abort_va)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dabort |=> $stable(fsr_q) && $stable(far_q));
  a_r7_flush_src: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fsr |=> tlb_flush);
  a_r8_purge_va: assert property (@(posedge clk) disable iff (!rst_n)
    wr_far |=> tlb_purge && (purge_va == $past(wr_data)));
  a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fsr && !wr_far) |=> !tlb_flush && !tlb_purge);
endmodule

// File: tb/mmu_cfg_regs_tb.sv
module mmu_cfg_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        dabort = 1'b0, pabort = 1'b0;
  logic [3:0]  abort_dom = '0;
  logic [2:0]  abort_type = '0;
  logic        abort_ext = 1'b0;
  logic [31:0] abort_va = '0;
  logic [9:0]  ctrl_flags;
  logic [31:0] table_base, dom_perm, purge_va;
  logic        tlb_flush, tlb_purge;
  int n_chk = 0, n_fail = 0;

  mmu_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .dabort(dabort), .pabort(pabort),
    .abort_dom(abort_dom), .abort_type(abort_type), .abort_ext(abort_ext),
    .abort_va(abort_va), .ctrl_flags(ctrl_flags), .table_base(table_base),
    .dom_perm(dom_perm), .tlb_flush(tlb_flush), .tlb_purge(tlb_purge),
    .purge_va(purge_va));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] v);
    @(negedge clk); reg_sel = sel; #1; v = rd_data;
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic abort(input logic is_data, input logic [3:0] dm, input logic [2:0] ty,
                       input logic ex, input logic [31:0] va);
    @(negedge clk);
    dabort = is_data; pabort = !is_data;
    abort_dom = dm; abort_type = ty; abort_ext = ex; abort_va = va;
    @(posedge clk); #1; dabort = 1'b0; pabort = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd1, v); chk("R1 ctrl reset", v, 32'h40);
    rd(4'd2, v); chk("R1 base reset", v, 0);
    rd(4'd3, v); chk("R1 dom reset", v, 0);
    rd(4'd5, v); chk("R1 fsr reset", v, 0);
    rd(4'd6, v); chk("R1 far reset", v, 0);
    chk("R1 strobes reset", {30'd0, tlb_flush, tlb_purge}, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); chk("R2 ctrl ones", v, 32'h3FF);
    wr(4'd1, 32'h0);         rd(4'd1, v); chk("R2 ctrl zeros", v, 32'h40);
    chk("R2 ctrl_flags port", {22'd0, ctrl_flags}, 32'h40);
    wr(4'd1, 32'hFFFF_FC05); rd(4'd1, v); chk("R2 ctrl sparse", v, 32'h45);
  endtask

  task automatic t_base_dom;
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R3 base read", v, 32'hFFFF_C000);
    chk("R3 base port", table_base, 32'hFFFF_C000);
    wr(4'd3, 32'hA5A5_0F3C); rd(4'd3, v); chk("R4 dom read", v, 32'hA5A5_0F3C);
    chk("R4 dom field0", {30'd0, dom_perm[1:0]}, 0);
    chk("R4 dom field1", {30'd0, dom_perm[3:2]}, 3);
    chk("R4 dom field15", {30'd0, dom_perm[31:30]}, 2);
  endtask

  task automatic t_faults;
    logic [31:0] v;
    abort(1'b1, 4'd9, 3'd5, 1'b1, 32'h1234_5678);
    rd(4'd5, v); chk("R5 fsr capture", v, 32'h9B);
    rd(4'd6, v); chk("R5 far capture", v, 32'h1234_5678);
    abort(1'b0, 4'd3, 3'd2, 1'b0, 32'hDEAD_BEEF);
    rd(4'd5, v); chk("R6 fsr held", v, 32'h9B);
    rd(4'd6, v); chk("R6 far held", v, 32'h1234_5678);
  endtask

  task automatic t_maint;
    logic [31:0] v;
    wr(4'd5, 32'hFF);
    chk("R7 flush high", {31'd0, tlb_flush}, 1);
    chk("R7 no purge", {31'd0, tlb_purge}, 0);
    @(posedge clk); #1; chk("R7 flush one cycle", {31'd0, tlb_flush}, 0);
    rd(4'd5, v); chk("R7 fsr unchanged", v, 32'h9B);
    wr(4'd6, 32'hCAFE_0000);
    chk("R8 purge high", {31'd0, tlb_purge}, 1);
    chk("R8 purge va", purge_va, 32'hCAFE_0000);
    chk("R8 no flush", {31'd0, tlb_flush}, 0);
    @(posedge clk); #1; chk("R8 purge one cycle", {31'd0, tlb_purge}, 0);
    rd(4'd6, v); chk("R8 far unchanged", v, 32'h1234_5678);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 4'd5; wr_data = 32'hFF;
    dabort = 1'b1; abort_dom = 4'd2; abort_type = 3'd1; abort_ext = 1'b0;
    abort_va = 32'h0000_B000;
    @(posedge clk); #1; wr_en = 1'b0; dabort = 1'b0;
    chk("R10 flush still fires", {31'd0, tlb_flush}, 1);
    rd(4'd5, v); chk("R10 abort wins", v, 32'h22);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    foreach (v[i]) begin end
    for (int s = 0; s < 16; s++) begin
      if (s == 0 || s == 4 || s >= 7) begin
        wr(4'(s), 32'hFFFF_FFFF);
        chk("R9 no strobe", {30'd0, tlb_flush, tlb_purge}, 0);
        rd(4'(s), v); chk("R9 reserved reads zero", v, 0);
      end
    end
    rd(4'd1, v); chk("R9 ctrl intact", v, 32'h45);
    rd(4'd2, v); chk("R9 base intact", v, 32'hFFFF_C000);
    rd(4'd3, v); chk("R9 dom intact", v, 32'hA5A5_0F3C);
    rd(4'd5, v); chk("R9 fsr intact", v, 32'h22);
    rd(4'd6, v); chk("R9 far intact", v, 32'h0000_B000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_base_dom();
    t_faults();
    t_maint();
    t_collide();
    t_reserved();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule